// File: doc/BRIEF.md
# Dual-Source Output Buffer Interrupt Arbiter

This block joins two byte producers, a keyboard source and an auxiliary (pointing device) source, onto one host read path. Each source is held in a one-byte register with a valid flag; the two valid flags form a two-bit pending mask. From that mask and an 8-bit mode byte, the block derives the output-buffer-full flags, the auxiliary-buffer-full flags and two level interrupt lines. The flags are presented both as status-register bits and as output-port mirror bits.

Keyboard data always has priority. The auxiliary byte is returned, and the auxiliary flags and interrupt are raised, only when the auxiliary source is the only one pending. A host data read takes the byte of the chosen source and clears that source's pending bit. The flags and interrupts follow the new pending mask in the same cycle.

Top module: `kbc_obuf_arbiter`

## Requirements
- R1: A pulse on `kbd_load` (or `aux_load`) captures the byte into that source's holding register and sets pending bit 0 (or bit 1) at the next clock edge. If a load and a consuming read hit the same source in the same cycle, the load wins: the new byte is kept and the bit stays set.
- R2: `sts_full` (status bit 0) and `oport_full` (output-port bit 4) are 1 exactly when the pending mask is nonzero.
- R3: `sts_aux` (status bit 5) and `oport_aux` (output-port bit 5) are 1 only when the pending mask equals 2'b10 (auxiliary alone).
- R4: `irq_aux` is 1 only when the pending mask equals 2'b10 and `mode[1]` is 1.
- R5: `irq_kbd` is 1 when pending bit 0 is set, `mode[0]` is 1 and `mode[4]` (keyboard disable) is 0.
- R6: `rd_data` shows the auxiliary holding byte when the pending mask equals 2'b10. In every other case, including an empty mask, it shows the keyboard holding byte.
- R7: A `host_rd` pulse clears only the pending bit of the source selected by R6. A read with an empty mask changes no state.
- R8: While `rst_n` is low, both interrupts are 0 and the pending mask is cleared. Both holding bytes reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 8 | Mode byte (bit 0 kbd irq enable, bit 1 aux irq enable, bit 4 kbd disable) |
| kbd_load | input | 1 | Keyboard byte valid strobe |
| kbd_byte | input | 8 | Keyboard byte |
| aux_load | input | 1 | Auxiliary byte valid strobe |
| aux_byte | input | 8 | Auxiliary byte |
| host_rd | input | 1 | Host data-port read strobe (consumes the selected byte) |
| rd_data | output | 8 | Byte returned to the host |
| pend | output | 2 | Pending mask {aux, kbd} |
| sts_full | output | 1 | Status bit 0 |
| sts_aux | output | 1 | Status bit 5 |
| oport_full | output | 1 | Output-port bit 4 |
| oport_aux | output | 1 | Output-port bit 5 |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |

## Verification
Loads and reads take effect at the first rising edge after they are presented. Every flag, interrupt and `rd_data` is a combinational function of the registered state and `mode`, so all of them are due right after that same edge, with no further delay. The bench drives inputs on the falling edge, advances its own model on the rising edge, and compares every output at the following falling edge. Changes to `mode` alone are visible within the same cycle, and the bench checks them after the next edge together with the rest.

// File: rtl/kbc_obuf_arbiter.sv
module kbc_obuf_arbiter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        mode,
  input  logic              kbd_load,
  input  logic [BYTE_W-1:0] kbd_byte,
  input  logic              aux_load,
  input  logic [BYTE_W-1:0] aux_byte,
  input  logic              host_rd,
  output logic [BYTE_W-1:0] rd_data,
  output logic [1:0]        pend,
  output logic              sts_full,
  output logic              sts_aux,
  output logic              oport_full,
  output logic              oport_aux,
  output logic              irq_kbd,
  output logic              irq_aux
);

  logic [BYTE_W-1:0] kbd_q, aux_q;
  logic              kbd_v, aux_v;
  logic              aux_only, take_kbd, take_aux;

  assign aux_only = aux_v & ~kbd_v;
  assign take_aux = host_rd & aux_only;
  assign take_kbd = host_rd & kbd_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kbd_v <= 1'b0;
      kbd_q <= '0;
    end else if (kbd_load) begin
      kbd_v <= 1'b1;
      kbd_q <= kbd_byte;
    end else if (take_kbd) begin
      kbd_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aux_v <= 1'b0;
      aux_q <= '0;
    end else if (aux_load) begin
      aux_v <= 1'b1;
      aux_q <= aux_byte;
    end else if (take_aux) begin
      aux_v <= 1'b0;
    end
  end

  assign pend       = {aux_v, kbd_v};
  assign rd_data    = aux_only ? aux_q : kbd_q;
  assign sts_full   = kbd_v | aux_v;
  assign oport_full = kbd_v | aux_v;
  assign sts_aux    = aux_only;
  assign oport_aux  = aux_only;
  assign irq_aux    = rst_n & aux_only & mode[1];
  assign irq_kbd    = rst_n & kbd_v & mode[0] & ~mode[4];

endmodule

module kbc_obuf_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] mode,
  input logic       kbd_load,
  input logic       aux_load,
  input logic       host_rd,
  input logic [1:0] pend,
  input logic       sts_full,
  input logic       sts_aux,
  input logic       oport_aux,
  input logic       irq_kbd,
  input logic       irq_aux
);

  a_r1_kbd_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_load |=> pend[0]);

  a_r1_aux_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    aux_load |=> pend[1]);

  a_r2_full_tracks_pend: assert property (@(posedge clk) disable iff (!rst_n)
    sts_full == (pend != 2'b00));

  a_r3_aux_flag_solo: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_aux | oport_aux) |-> (pend == 2'b10));

  a_r4_aux_irq_solo: assert property (@(posedge clk) disable iff (!rst_n)
    irq_aux |-> (pend == 2'b10) && mode[1]);

  a_r5_kbd_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_kbd |-> pend[0] && mode[0] && !mode[4]);

  a_r7_aux_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && pend == 2'b10 && !aux_load && !kbd_load |=> pend == 2'b00);

  a_r7_kbd_read_keeps_aux: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && pend == 2'b11 && !aux_load && !kbd_load |=> pend == 2'b10);

  always_comb begin
    if (rst_n === 1'b0) begin
      a_r8_irq_low_in_reset: assert (!irq_kbd && !irq_aux);
    end
  end

endmodule

bind kbc_obuf_arbiter kbc_obuf_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .kbd_load(kbd_load),
  .aux_load(aux_load), .host_rd(host_rd), .pend(pend),
  .sts_full(sts_full), .sts_aux(sts_aux), .oport_aux(oport_aux),
  .irq_kbd(irq_kbd), .irq_aux(irq_aux)
);

// File: tb/kbc_obuf_arbiter_tb_top.sv
module kbc_obuf_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] mode = 8'h03;
  logic kbd_load = 1'b0, aux_load = 1'b0, host_rd = 1'b0;
  logic [7:0] kbd_byte = '0, aux_byte = '0;
  logic [7:0] rd_data;
  logic [1:0] pend;
  logic sts_full, sts_aux, oport_full, oport_aux, irq_kbd, irq_aux;

  int n_vec = 0, n_bad = 0;
  logic m_kv = 0, m_av = 0;
  logic [7:0] m_kq = 0, m_aq = 0;
  logic done = 0;

  always #2 clk = ~clk;

  kbc_obuf_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .kbd_load(kbd_load),
    .kbd_byte(kbd_byte), .aux_load(aux_load), .aux_byte(aux_byte),
    .host_rd(host_rd), .rd_data(rd_data), .pend(pend),
    .sts_full(sts_full), .sts_aux(sts_aux), .oport_full(oport_full),
    .oport_aux(oport_aux), .irq_kbd(irq_kbd), .irq_aux(irq_aux)
  );

  function automatic logic solo(input logic kv, input logic av);
    return av & ~kv;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic s;
    s = solo(m_kv, m_av);
    chk("R1", "pend", {6'd0, pend}, {6'd0, m_av, m_kv});
    chk("R2", "sts_full", {7'd0, sts_full}, {7'd0, m_kv | m_av});
    chk("R2", "oport_full", {7'd0, oport_full}, {7'd0, m_kv | m_av});
    chk("R3", "sts_aux", {7'd0, sts_aux}, {7'd0, s});
    chk("R3", "oport_aux", {7'd0, oport_aux}, {7'd0, s});
    chk("R4", "irq_aux", {7'd0, irq_aux}, {7'd0, s & mode[1] & rst_n});
    chk("R5", "irq_kbd", {7'd0, irq_kbd}, {7'd0, m_kv & mode[0] & ~mode[4] & rst_n});
    chk("R6", "rd_data", rd_data, s ? m_aq : m_kq);
  endtask

  task automatic step(input logic kl, input logic [7:0] kb, input logic al,
                      input logic [7:0] ab, input logic rd, input logic [7:0] md);
    logic s;
    @(negedge clk);
    kbd_load = kl; kbd_byte = kb; aux_load = al; aux_byte = ab; host_rd = rd; mode = md;
    s = solo(m_kv, m_av);
    @(posedge clk);
    if (!rst_n) begin
      m_kv = 0; m_av = 0; m_kq = 0; m_aq = 0;
    end else begin
      if (kl) begin m_kv = 1; m_kq = kb; end
      else if (rd && m_kv) m_kv = 0;
      if (al) begin m_av = 1; m_aq = ab; end
      else if (rd && s) m_av = 0;
    end
    @(negedge clk);
    check_all();
    kbd_load = 0; aux_load = 0; host_rd = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    // R8: reset state, even with loads presented
    step(1, 8'hAB, 1, 8'hCD, 0, 8'h03);
    chk("R8", "pend_in_reset", {6'd0, pend}, 8'h00);
    chk("R8", "irq_in_reset", {6'd0, irq_kbd, irq_aux}, 8'h00);
    @(negedge clk); rst_n = 1;
    // R7: read with nothing pending changes nothing, R6 shows keyboard byte
    step(0, 0, 0, 0, 1, 8'h03);
    chk("R7", "empty_read_pend", {6'd0, pend}, 8'h00);
    // aux alone: R3 R4 R6
    step(0, 0, 1, 8'h5A, 0, 8'h03);
    chk("R4", "aux_solo_irq", {7'd0, irq_aux}, 8'h01);
    chk("R6", "aux_solo_data", rd_data, 8'h5A);
    // both pending: keyboard wins
    step(1, 8'h3C, 0, 0, 0, 8'h03);
    chk("R3", "both_no_aux_flag", {7'd0, sts_aux}, 8'h00);
    chk("R6", "both_kbd_data", rd_data, 8'h3C);
    // R5: keyboard disable masks irq
    step(0, 0, 0, 0, 0, 8'h13);
    chk("R5", "kbd_disabled_irq", {7'd0, irq_kbd}, 8'h00);
    // R7: read kbd leaves aux pending
    step(0, 0, 0, 0, 1, 8'h03);
    chk("R7", "kbd_read_leaves_aux", {6'd0, pend}, 8'h02);
    // R1: load and read same source same cycle, load wins
    step(0, 0, 1, 8'h77, 1, 8'h03);
    chk("R1", "load_beats_read", rd_data, 8'h77);
    step(0, 0, 0, 0, 1, 8'h01);
    chk("R7", "aux_read_clears", {6'd0, pend}, 8'h00);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[15:8], r[2] & r[3], r[23:16], r[4], {3'd0, r[5], 2'd0, r[6], r[7]});
      if (r[31:28] == 4'hF) begin
        @(negedge clk); rst_n = 0;
        step(0, 0, 0, 0, 0, 8'h03);
        chk("R8", "mid_reset_pend", {6'd0, pend}, 8'h00);
        @(negedge clk); rst_n = 1;
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule